// File: doc/BRIEF.md
# Signed Multiply Unit with Multiplicand and Product Registers

This block is the multiply section of a fixed-point signal-processing datapath. A 16-bit multiplicand register (T) is loaded from the data operand, and a multiply operation forms the signed product of T and either the data operand or a short immediate. The full-width result goes into a 32-bit product register (P). Both registers are visible at the ports.

The block also carries the operations that move the product into the accumulator. The caller presents the current accumulator on `acc_i`. The block returns the updated value on `acc_o` within the same cycle. P can be added to the accumulator, subtracted from it, or copied into it.

Two fused operations load T and accumulate P in one cycle. One of them also raises a request to copy the addressed data word one address higher. Any accumulate that happens in the same cycle as a T load uses the P value that was held before that cycle.

Top module: `mpy_unit`

## Requirements
- R1: While `rst_n` is low, `t_o` and `p_o` are zero.
- R2: Operation code 1 loads `data_i` into T at the clock edge. P is unchanged.
- R3: Operation code 2 writes the two's-complement product of T and `data_i` into P at the clock edge, as the full 32 bits without saturation. For example, -32768 times -32768 gives 0x40000000.
- R4: Operation code 3 writes into P the product of T and the 13-bit `imm_i` sign-extended to 16 bits.
- R5: Operation code 4 drives `acc_o` with `acc_i` plus P, modulo 2^32, in the same cycle.
- R6: Operation code 5 drives `acc_o` with `acc_i` minus P, modulo 2^32, in the same cycle.
- R7: Operation code 6 drives `acc_o` with P in the same cycle.
- R8: Operation code 7 loads `data_i` into T at the clock edge. In the same cycle it drives `acc_o` with `acc_i` plus the P value held before that edge, and `move_req_o` stays low.
- R9: Operation code 8 acts as code 7 and also holds `move_req_o` high for that cycle. `move_req_o` is low for every other code.
- R10: Code 0 and codes 9 to 15 leave T and P unchanged and drive `acc_o` equal to `acc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_i | input | 4 | Operation code |
| data_i | input | 16 | Data operand |
| imm_i | input | 13 | Immediate multiplier operand |
| acc_i | input | 32 | Current accumulator value |
| t_o | output | 16 | Multiplicand register |
| p_o | output | 32 | Product register |
| acc_o | output | 32 | Updated accumulator value |
| move_req_o | output | 1 | Request to copy the data word to the next higher address |

## Verification
On every cycle, the assertions check the following:
- P holds through any operation that does not multiply.
- T takes the data operand after a load.
- Idle codes pass the accumulator through unchanged.
- The move request only ever goes with an add of P.
- Code 6 copies P into the accumulator output.

The exact product values can only be shown by the bench's sweeps. These include every 13-bit immediate, the corner operands including the most-negative square, and the ordering in the fused operations where the accumulate must see the old P.

// File: rtl/mpy_pkg.sv
package mpy_pkg;
  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_LDT    = 4'd1,
    OP_MUL    = 4'd2,
    OP_MULI   = 4'd3,
    OP_ADDP   = 4'd4,
    OP_SUBP   = 4'd5,
    OP_LDACC  = 4'd6,
    OP_LTADD  = 4'd7,
    OP_LTMOVE = 4'd8
  } op_e;
endpackage

// File: rtl/mpy_array.sv
module mpy_array #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 13,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] mplier;

  generate
    if (IMM_W < DATA_W) begin : g_ext
      assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign mplier = use_imm_i ? imm_ext : data_i;

  logic signed [PROD_W-1:0] a_s;
  logic signed [PROD_W-1:0] b_s;
  logic signed [PROD_W-1:0] p_s;
  assign a_s    = PROD_W'($signed(mcand_i));
  assign b_s    = PROD_W'($signed(mplier));
  assign p_s    = a_s * b_s;
  assign prod_o = p_s;
endmodule

// File: rtl/mpy_acc_path.sv
module mpy_acc_path
  import mpy_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  op_e              op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] p_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             move_req_o
);
  always_comb begin
    acc_o      = acc_i;
    move_req_o = 1'b0;
    case (op_i)
      OP_ADDP, OP_LTADD: acc_o = acc_i + p_i;
      OP_LTMOVE: begin
        acc_o      = acc_i + p_i;
        move_req_o = 1'b1;
      end
      OP_SUBP:  acc_o = acc_i - p_i;
      OP_LDACC: acc_o = p_i;
      default:  acc_o = acc_i;
    endcase
  end
endmodule

// File: rtl/mpy_unit.sv
module mpy_unit
  import mpy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 13,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PROD_W-1:0] acc_i,
  output logic [DATA_W-1:0] t_o,
  output logic [PROD_W-1:0] p_o,
  output logic [PROD_W-1:0] acc_o,
  output logic              move_req_o
);
  op_e op_c;
  assign op_c = op_e'(op_i);

  logic [DATA_W-1:0] t_q, t_d;
  logic [PROD_W-1:0] p_q, p_d;
  logic              t_en, p_en;
  logic [PROD_W-1:0] prod;

  mpy_array #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_array (
    .mcand_i  (t_q),
    .data_i   (data_i),
    .imm_i    (imm_i),
    .use_imm_i(op_c == OP_MULI),
    .prod_o   (prod)
  );

  mpy_acc_path #(.ACC_W(PROD_W)) u_acc (
    .op_i      (op_c),
    .acc_i     (acc_i),
    .p_i       (p_q),
    .acc_o     (acc_o),
    .move_req_o(move_req_o)
  );

  // next-state
  always_comb begin
    t_en = (op_c == OP_LDT) || (op_c == OP_LTADD) || (op_c == OP_LTMOVE);
    p_en = (op_c == OP_MUL) || (op_c == OP_MULI);
    t_d  = data_i;
    p_d  = prod;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      p_q <= '0;
    end else begin
      if (t_en) t_q <= t_d;
      if (p_en) p_q <= p_d;
    end
  end

  assign t_o = t_q;
  assign p_o = p_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (t_q == '0 && p_q == '0)); // R1
  AST_T_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd1) |=> (t_o == $past(data_i))); // R2
  AST_P_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 4'd2 && op_i != 4'd3) |=> $stable(p_o)); // R10
  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd2 && data_i == '0) |=> (p_o == '0)); // R3
  AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6) |-> (acc_o == p_o)); // R7
  AST_MOVE_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    move_req_o |-> (acc_o == acc_i + p_o)); // R9
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i > 4'd8) |-> (acc_o == acc_i && !move_req_o)); // R10
endmodule

// File: tb/tb_mpy_unit.sv
`timescale 1ns/1ps
module tb_mpy_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [15:0] data_i;
  logic [12:0] imm_i;
  logic [31:0] acc_i;
  logic [15:0] t_o;
  logic [31:0] p_o;
  logic [31:0] acc_o;
  logic        move_req_o;

  int tests = 0;
  int fails = 0;
  logic [15:0] t_m;
  logic [31:0] p_m;

  always #5 clk = ~clk;

  mpy_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .data_i(data_i), .imm_i(imm_i),
    .acc_i(acc_i), .t_o(t_o), .p_o(p_o), .acc_o(acc_o), .move_req_o(move_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] smul(input logic [15:0] a, input logic [15:0] b);
    longint x = longint'($signed(a)) * longint'($signed(b));
    return x[31:0];
  endfunction

  // Drives one operation and checks same-cycle and post-edge results.
  task automatic step(input string req, input int op, input logic [15:0] d,
                      input logic [12:0] im, input logic [31:0] acc);
    logic [31:0] exp_acc;
    logic        exp_mv;
    logic [15:0] imx;
    @(negedge clk);
    op_i = 4'(op); data_i = d; imm_i = im; acc_i = acc;
    #1;
    imx = {{3{im[12]}}, im};
    exp_mv = (op == 8);
    case (op)
      4, 7, 8: exp_acc = acc + p_m;
      5:       exp_acc = acc - p_m;
      6:       exp_acc = p_m;
      default: exp_acc = acc;
    endcase
    check({req, " acc"}, acc_o, exp_acc);
    check({req, " move"}, 32'(move_req_o), 32'(exp_mv));
    if (op == 2) p_m = smul(t_m, d);
    if (op == 3) p_m = smul(t_m, imx);
    if (op == 1 || op == 7 || op == 8) t_m = d;
    @(posedge clk); #1;
    check({req, " T"}, 32'(t_o), 32'(t_m));
    check({req, " P"}, p_o, p_m);
  endtask

  logic [15:0] corners [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                               16'h8000, 16'h1234, 16'hEDCB, 16'h0100};

  initial begin
    #200000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_i = '0; data_i = '0; imm_i = '0; acc_i = '0;
    t_m = '0; p_m = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 T", 32'(t_o), 32'h0);
    check("R1 P", p_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2, R3 corner sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        step("R2", 1, corners[i], 13'h0, 32'h0);
        step("R3", 2, corners[j], 13'h0, 32'h0);
      end
    step("R2", 1, 16'h8000, 13'h0, 32'h0);
    step("R3", 2, 16'h8000, 13'h0, 32'h0);
    check("R3 min*min", p_o, 32'h40000000);

    // R4 every immediate against two multiplicands
    step("R2", 1, 16'h8000, 13'h0, 32'h0);
    for (int k = 0; k < 8192; k++) step("R4", 3, 16'hAAAA, 13'(k), 32'h0);
    step("R2", 1, 16'h3039, 13'h0, 32'h0);
    for (int k = 0; k < 8192; k++) step("R4", 3, 16'h5555, 13'(k), 32'h0);
    step("R4", 3, 16'h0, 13'h1000, 32'h0);
    check("R4 neg imm", p_o, smul(16'h3039, 16'hF000));

    // R5..R7 accumulator operations across acc values with wrap
    for (int i = 0; i < 8; i++) begin
      step("R2", 1, corners[i], 13'h0, 32'h0);
      step("R3", 2, corners[7-i], 13'h0, 32'h0);
      step("R5", 4, 16'h0, 13'h0, 32'hFFFF_FFF0 + 32'(i));
      step("R6", 5, 16'h0, 13'h0, 32'h0000_0003 * 32'(i));
      step("R7", 6, 16'h0, 13'h0, 32'hDEAD_BEEF);
    end

    // R8/R9 accumulate uses old P, then the new T takes effect on the next multiply
    step("R2", 1, 16'h0010, 13'h0, 32'h0);
    step("R3", 2, 16'h0020, 13'h0, 32'h0);
    step("R8", 7, 16'hFFFE, 13'h0, 32'h0000_1000);
    step("R3", 2, 16'h0003, 13'h0, 32'h0);
    check("R8 new T product", p_o, 32'hFFFF_FFFA);
    step("R9", 8, 16'h7FFF, 13'h0, 32'h8000_0000);
    step("R9", 8, 16'h8001, 13'h0, 32'h1);
    step("R3", 2, 16'h0002, 13'h0, 32'h0);

    // R10 idle codes
    step("R10", 0, 16'h5A5A, 13'h1FFF, 32'h1234_5678);
    for (int c = 9; c < 16; c++) step("R10", c, 16'hA5A5, 13'h0AAA, 32'(c) * 32'h0101_0101);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule